// File: doc/BRIEF.md
# Mixed-Width Dual-Port RAM

This block is an 8,192-bit memory with two independent access ports, A and B. Each port's data width is fixed at elaboration to 1, 2, 4, 8 or 16 bits, and that width sets the port's depth. Port A can write in one word size while port B reads the same bits in another.

Both ports see one linear bit array. Bit k of word w on a port of width W is array bit w*W+k, and the same rule holds for each port's own width. Every bit has a power-on value taken from an elaboration parameter, so a port whose write enable is never asserted turns the block into a ROM.

Each control input can be set to active high or active low per port. Both ports are synchronous to one shared clock, and a read has one cycle of latency. Greater width is built by placing instances side by side on shared addresses. Greater depth is built by selecting between instances' read data on upper address bits.

Top module: `mixed_width_dpram`

## Requirements
- R1: Port widths are limited to 1, 2, 4, 8 or 16, checked at elaboration. A port's address has exactly log2(8192/width) bits, so its highest word (all-ones address) is reachable and no address falls outside the array.
- R2: Port bit k of word w is array bit w*width+k on both ports. Data written on one port reads back on the other port under that mapping, whatever the two widths are.
- R3: A read presents the addressed word on the port's read data at the first rising clock edge after the cycle in which the address and read command are applied.
- R4: After power-on, array bit i equals bit i of the INIT_BITS parameter. Reads return these values until a write changes them.
- R5: In a cycle where a port writes, that port's read data keeps its previous value.
- R6: When a port's clock enable or port enable is inactive, that port neither writes nor updates its read data.
- R7: When both ports write overlapping bits in the same cycle, port A's data is stored in the overlap. Port B's bits outside the overlap are still stored.
- R8: A port reading bits that the other port writes in the same cycle returns the contents from before that write.
- R9: The polarity parameters A_CTRL_INV and B_CTRL_INV have bit 0 for clock enable, bit 1 for port enable and bit 2 for write enable. A 1 makes that input active low.
- R10: While rst_n is low, both read data outputs are zero. Reset leaves the array contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset of the read registers |
| a_ce | input | 1 | Port A clock enable |
| a_en | input | 1 | Port A port enable |
| a_we | input | 1 | Port A write enable |
| a_addr | input | log2(8192/A_WIDTH) | Port A word address |
| a_wdata | input | A_WIDTH | Port A write data |
| a_rdata | output | A_WIDTH | Port A registered read data |
| b_ce | input | 1 | Port B clock enable |
| b_en | input | 1 | Port B port enable |
| b_we | input | 1 | Port B write enable |
| b_addr | input | log2(8192/B_WIDTH) | Port B word address |
| b_wdata | input | B_WIDTH | Port B write data |
| b_rdata | output | B_WIDTH | Port B registered read data |

## Verification
Two kinds of same-cycle event are provoked. In the first, both ports write in one cycle: a 4-bit port A write lands in one nibble of a 16-bit port B word that B is also writing. A later read must show A's nibble with B's other three nibbles. In the second, one port reads a word while the other port writes bits inside it in the same cycle. The read must return the earlier contents, and a following read must return the new bits. Expected values come from a flat bit array in the bench that applies B's write first and A's write second.

// File: rtl/mwdp_pkg.sv
package mwdp_pkg;

   localparam int unsigned MWDP_TOTAL_BITS = 8192;

   // Index of each polarity bit inside a *_CTRL_INV vector.
   localparam int unsigned POL_CE = 0;
   localparam int unsigned POL_EN = 1;
   localparam int unsigned POL_WE = 2;

   function automatic bit width_is_legal(input int unsigned w);
      return (w == 1) || (w == 2) || (w == 4) || (w == 8) || (w == 16);
   endfunction

   function automatic int unsigned addr_bits(input int unsigned total, input int unsigned w);
      return $clog2(total / w);
   endfunction

   typedef struct packed {
      logic act;
      logic wr;
      logic rd;
   } port_cmd_t;

endpackage

// File: rtl/mwdp_port_ctrl.sv
module mwdp_port_ctrl
   import mwdp_pkg::*;
#(
   parameter logic [2:0] CTRL_INV = 3'b000
) (
   input  logic      ce_pin,
   input  logic      en_pin,
   input  logic      we_pin,
   output port_cmd_t cmd
);

   logic [2:0] raw;
   logic [2:0] lvl;

   assign raw[POL_CE] = ce_pin;
   assign raw[POL_EN] = en_pin;
   assign raw[POL_WE] = we_pin;

   for (genvar g = 0; g < 3; g++) begin : g_pol
      if (CTRL_INV[g]) begin : g_low
         assign lvl[g] = ~raw[g];
      end else begin : g_high
         assign lvl[g] = raw[g];
      end
   end

   assign cmd.act = lvl[POL_CE] & lvl[POL_EN];
   assign cmd.wr  = cmd.act & lvl[POL_WE];
   assign cmd.rd  = cmd.act & ~lvl[POL_WE];

endmodule

// File: rtl/mwdp_array.sv
module mwdp_array
   import mwdp_pkg::*;
#(
   parameter int unsigned              TOTAL_BITS = MWDP_TOTAL_BITS,
   parameter int unsigned              A_WIDTH    = 8,
   parameter int unsigned              B_WIDTH    = 8,
   parameter logic [TOTAL_BITS-1:0]    INIT_BITS  = '0,
   localparam int unsigned             A_AW       = addr_bits(TOTAL_BITS, A_WIDTH),
   localparam int unsigned             B_AW       = addr_bits(TOTAL_BITS, B_WIDTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  port_cmd_t          a_cmd,
   input  logic [A_AW-1:0]    a_addr,
   input  logic [A_WIDTH-1:0] a_wdata,
   output logic [A_WIDTH-1:0] a_rdata,
   input  port_cmd_t          b_cmd,
   input  logic [B_AW-1:0]    b_addr,
   input  logic [B_WIDTH-1:0] b_wdata,
   output logic [B_WIDTH-1:0] b_rdata
);

   localparam int unsigned IDX_W = $clog2(TOTAL_BITS);

   logic [TOTAL_BITS-1:0] bits = INIT_BITS;
   logic [IDX_W-1:0]      a_base;
   logic [IDX_W-1:0]      b_base;
   logic [A_WIDTH-1:0]    a_slice;
   logic [B_WIDTH-1:0]    b_slice;

   assign a_base  = IDX_W'(a_addr) * IDX_W'(A_WIDTH);
   assign b_base  = IDX_W'(b_addr) * IDX_W'(B_WIDTH);
   assign a_slice = bits[a_base +: A_WIDTH];
   assign b_slice = bits[b_base +: B_WIDTH];

   // B is applied first so that A's nonblocking update wins on overlap.
   always_ff @(posedge clk) begin
      if (b_cmd.wr) bits[b_base +: B_WIDTH] <= b_wdata;
      if (a_cmd.wr) bits[a_base +: A_WIDTH] <= a_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_rdata <= '0;
         b_rdata <= '0;
      end else begin
         if (a_cmd.rd) a_rdata <= a_slice;
         if (b_cmd.rd) b_rdata <= b_slice;
      end
   end

   assert_a_read_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
      a_cmd.rd |=> a_rdata == $past(a_slice));

   assert_b_read_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
      b_cmd.rd |=> b_rdata == $past(b_slice));

   assert_a_hold_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      a_cmd.wr |=> $stable(a_rdata));

   assert_b_hold_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      b_cmd.wr |=> $stable(b_rdata));

   assert_a_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !a_cmd.act |=> $stable(a_rdata));

   assert_b_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !b_cmd.act |=> $stable(b_rdata));

   assert_a_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      a_cmd.wr |=> bits[$past(a_base) +: A_WIDTH] == $past(a_wdata));

   assert_b_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (b_cmd.wr && !a_cmd.wr) |=> bits[$past(b_base) +: B_WIDTH] == $past(b_wdata));

   assert_cmd_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_cmd.wr && a_cmd.rd) && !(b_cmd.wr && b_cmd.rd));

endmodule

// File: rtl/mixed_width_dpram.sv
module mixed_width_dpram
   import mwdp_pkg::*;
#(
   parameter int unsigned                  A_WIDTH    = 8,
   parameter int unsigned                  B_WIDTH    = 8,
   parameter logic [2:0]                   A_CTRL_INV = 3'b000,
   parameter logic [2:0]                   B_CTRL_INV = 3'b000,
   parameter logic [MWDP_TOTAL_BITS-1:0]   INIT_BITS  = '0,
   localparam int unsigned                 A_AW       = addr_bits(MWDP_TOTAL_BITS, A_WIDTH),
   localparam int unsigned                 B_AW       = addr_bits(MWDP_TOTAL_BITS, B_WIDTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               a_ce,
   input  logic               a_en,
   input  logic               a_we,
   input  logic [A_AW-1:0]    a_addr,
   input  logic [A_WIDTH-1:0] a_wdata,
   output logic [A_WIDTH-1:0] a_rdata,
   input  logic               b_ce,
   input  logic               b_en,
   input  logic               b_we,
   input  logic [B_AW-1:0]    b_addr,
   input  logic [B_WIDTH-1:0] b_wdata,
   output logic [B_WIDTH-1:0] b_rdata
);

   // R1: elaboration-time shape checks
   if (!width_is_legal(A_WIDTH)) begin : g_bad_a
      $error("A_WIDTH must be 1, 2, 4, 8 or 16");
   end
   if (!width_is_legal(B_WIDTH)) begin : g_bad_b
      $error("B_WIDTH must be 1, 2, 4, 8 or 16");
   end
   if ((1 << A_AW) * A_WIDTH != MWDP_TOTAL_BITS) begin : g_bad_a_depth
      $error("port A depth does not cover the array");
   end
   if ((1 << B_AW) * B_WIDTH != MWDP_TOTAL_BITS) begin : g_bad_b_depth
      $error("port B depth does not cover the array");
   end

   port_cmd_t a_cmd;
   port_cmd_t b_cmd;

   mwdp_port_ctrl #(.CTRL_INV(A_CTRL_INV)) u_ctrl_a (
      .ce_pin (a_ce),
      .en_pin (a_en),
      .we_pin (a_we),
      .cmd    (a_cmd)
   );

   mwdp_port_ctrl #(.CTRL_INV(B_CTRL_INV)) u_ctrl_b (
      .ce_pin (b_ce),
      .en_pin (b_en),
      .we_pin (b_we),
      .cmd    (b_cmd)
   );

   mwdp_array #(
      .TOTAL_BITS (MWDP_TOTAL_BITS),
      .A_WIDTH    (A_WIDTH),
      .B_WIDTH    (B_WIDTH),
      .INIT_BITS  (INIT_BITS)
   ) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .a_cmd   (a_cmd),
      .a_addr  (a_addr),
      .a_wdata (a_wdata),
      .a_rdata (a_rdata),
      .b_cmd   (b_cmd),
      .b_addr  (b_addr),
      .b_wdata (b_wdata),
      .b_rdata (b_rdata)
   );

   assert_reset_clears_R10: assert property (@(posedge clk)
      !rst_n |-> (a_rdata == '0 && b_rdata == '0));

   assert_pol_a_we_R9: assert property (@(posedge clk) disable iff (!rst_n)
      a_cmd.wr |-> ((a_we ^ A_CTRL_INV[POL_WE]) && (a_ce ^ A_CTRL_INV[POL_CE])
                    && (a_en ^ A_CTRL_INV[POL_EN])));

endmodule

// File: tb/mixed_width_dpram_bench.sv
`timescale 1ns/1ps
module mixed_width_dpram_bench;

   localparam int unsigned N    = 8192;
   localparam int unsigned AW   = 4;
   localparam int unsigned BW   = 16;
   localparam int unsigned ADEP = N / AW;
   localparam int unsigned BDEP = N / BW;
   localparam int unsigned AAB  = $clog2(ADEP);
   localparam int unsigned BAB  = $clog2(BDEP);
   localparam logic [2:0]  AINV = 3'b110;   // A: port enable and write enable active low
   localparam logic [2:0]  BINV = 3'b000;

   function automatic logic [N-1:0] make_init();
      logic [N-1:0] v;
      for (int i = 0; i < N; i++) v[i] = ((i % 3) == 0) ^ ((i >> 5) & 1);
      return v;
   endfunction

   localparam logic [N-1:0] INIT = make_init();

   logic           clk = 0;
   logic           rst_n = 0;
   logic           a_ce = 0, a_en = 1, a_we = 1;
   logic [AAB-1:0] a_addr = '0;
   logic [AW-1:0]  a_wdata = '0;
   logic [AW-1:0]  a_rdata;
   logic           b_ce = 0, b_en = 0, b_we = 0;
   logic [BAB-1:0] b_addr = '0;
   logic [BW-1:0]  b_wdata = '0;
   logic [BW-1:0]  b_rdata;

   logic [N-1:0]   model = INIT;
   logic [AW-1:0]  exp_a = '0;
   logic [BW-1:0]  exp_b = '0;
   int             checks = 0;
   int             failures = 0;

   always #4 clk = ~clk;

   mixed_width_dpram #(
      .A_WIDTH(AW), .B_WIDTH(BW), .A_CTRL_INV(AINV), .B_CTRL_INV(BINV), .INIT_BITS(INIT)
   ) u_mixed_width_dpram (
      .clk(clk), .rst_n(rst_n),
      .a_ce(a_ce), .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
      .b_ce(b_ce), .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
   );

   task automatic check_both(input string tag);
      checks++;
      if (a_rdata !== exp_a || b_rdata !== exp_b) begin
         failures++;
         $display("FAIL %s a_rdata=%h exp=%h b_rdata=%h exp=%h", tag, a_rdata, exp_a, b_rdata, exp_b);
      end
   endtask

   // One cycle with logical (active-high) controls; pins are derived per polarity.
   task automatic cyc(input logic ace, input logic aen, input logic awe,
                      input int aad, input logic [AW-1:0] awd,
                      input logic bce, input logic ben, input logic bwe,
                      input int bad, input logic [BW-1:0] bwd, input string tag);
      logic aact, bact;
      a_ce = ace ^ AINV[0]; a_en = aen ^ AINV[1]; a_we = awe ^ AINV[2];
      a_addr = AAB'(aad); a_wdata = awd;
      b_ce = bce ^ BINV[0]; b_en = ben ^ BINV[1]; b_we = bwe ^ BINV[2];
      b_addr = BAB'(bad); b_wdata = bwd;
      aact = ace & aen;
      bact = bce & ben;
      @(posedge clk);
      if (aact && !awe) exp_a = model[aad*AW +: AW];
      if (bact && !bwe) exp_b = model[bad*BW +: BW];
      if (bact && bwe) model[bad*BW +: BW] = bwd;
      if (aact && awe) model[aad*AW +: AW] = awd;
      @(negedge clk);
      check_both(tag);
   endtask

   task automatic a_rd(input int ad, input string tag);
      cyc(1, 1, 0, ad, '0, 0, 0, 0, 0, '0, tag);
   endtask
   task automatic b_rd(input int ad, input string tag);
      cyc(0, 0, 0, 0, '0, 1, 1, 0, ad, '0, tag);
   endtask

   initial begin
      #(8ns * 200000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      // R10: read registers zero under reset
      a_ce = 0; a_en = 1; a_we = 1; b_ce = 0; b_en = 0; b_we = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_both("R10 reset");
      rst_n = 1;
      @(negedge clk);

      // R4: full power-on sweep on both ports (ROM use, no writes)
      for (int i = 0; i < BDEP; i++) b_rd(i, "R4 init via B");
      for (int i = 0; i < ADEP; i++) a_rd(i, "R4 init via A");

      // R1: highest word of each port is reachable
      a_rd(ADEP - 1, "R1 top word A");
      b_rd(BDEP - 1, "R1 top word B");

      // R2: narrow writes on A, wide reads on B
      for (int i = 0; i < ADEP; i++)
         cyc(1, 1, 1, i, AW'(i * 7 + 5), 0, 0, 0, 0, '0, "R2 A write");
      for (int i = 0; i < BDEP; i++) b_rd(i, "R2 B reads A data");
      // R2: wide writes on B, narrow reads on A
      for (int i = 0; i < BDEP; i++)
         cyc(0, 0, 0, 0, '0, 1, 1, 1, i, BW'(i * 40503 + 17), "R2 B write");
      for (int i = 0; i < ADEP; i++) a_rd(i, "R2 A reads B data");

      // R3: alternating addresses, data follows one edge later
      for (int i = 0; i < 16; i++) a_rd((i * 97) % ADEP, "R3 latency A");
      for (int i = 0; i < 16; i++) b_rd((i * 37) % BDEP, "R3 latency B");

      // R5: write cycle keeps the port's previous read data
      a_rd(10, "R5 prime A");
      cyc(1, 1, 1, 10, 4'hA, 0, 0, 0, 0, '0, "R5 A write holds");
      a_rd(10, "R5 A readback");
      b_rd(3, "R5 prime B");
      cyc(0, 0, 0, 0, '0, 1, 1, 1, 3, 16'hBEEF, "R5 B write holds");
      b_rd(3, "R5 B readback");

      // R6: clock enable or port enable low blocks the write and the read
      cyc(0, 1, 1, 20, 4'h3, 0, 0, 0, 0, '0, "R6 A ce low");
      a_rd(20, "R6 A unchanged");
      cyc(0, 0, 0, 0, '0, 1, 0, 1, 7, 16'h1234, "R6 B en low");
      b_rd(7, "R6 B unchanged");
      cyc(0, 1, 0, 0, '0, 0, 1, 0, 1, '0, "R6 idle read hold");

      // R9: A's enable is active low; pin high means inactive
      cyc(1, 0, 1, 21, 4'hC, 0, 0, 0, 0, '0, "R9 A en pin high blocks");
      a_rd(21, "R9 A unchanged");
      cyc(1, 1, 1, 22, 4'h6, 0, 0, 0, 0, '0, "R9 A low pins write");
      a_rd(22, "R9 A written");

      // R7: overlapping writes, A nibble 1 of B word 40
      cyc(1, 1, 1, 40 * 4 + 1, 4'h5, 1, 1, 1, 40, 16'hFEDC, "R7 both write");
      b_rd(40, "R7 A wins overlap");
      cyc(1, 1, 1, 41 * 4 + 3, 4'h0, 1, 1, 1, 41, 16'h9876, "R7 both write top");
      b_rd(41, "R7 A wins top nibble");

      // R8: read of bits under a same-cycle write returns old contents
      cyc(1, 1, 1, 50 * 4 + 2, 4'hE, 1, 1, 0, 50, '0, "R8 B reads old");
      b_rd(50, "R8 B sees new");
      cyc(1, 1, 0, 60 * 4, '0, 1, 1, 1, 60, 16'h4321, "R8 A reads old");
      a_rd(60 * 4, "R8 A sees new");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule